// File: doc/BRIEF.md
# Video Line and Frame Sequencer

This block divides the system clock into horizontal lines and groups the lines into frames for a 60 Hz or a 50 Hz display standard. The line period is not a whole number of clocks. A fixed-point phase accumulator with 12 fractional bits adds a per-standard increment once per line. The integer part of the sum is the length of the next line in clocks, and the fractional remainder carries into the following line. Over many lines the average length therefore matches the exact ratio.

A line counter runs inside each frame. The frame-level events are decoded from this counter. Vertical blank starts on a fixed line. An end-of-frame interrupt fires when the counter wraps, and a frame counter advances at the same point. A separate line count produces a periodic tick for an audio-update consumer. A 32-bit status word carries a vertical-blank flag and an interlace field bit.

The standard-select input is sampled only at frame boundaries. A mid-frame change therefore never produces a frame of mixed geometry.

Top module: `vid_seq`

## Requirements
- R1: After reset, line_num is 0, frame_count is 0, status is 0, the 60 Hz standard is active, and the first line lasts floor(INC60 / 4096) clocks.
- R2: line_tick is high for one clock on the last clock of each line. The length of each line is bits [31:12] of (previous fractional remainder + the active standard's increment), and bits [11:0] of that sum become the new remainder. Default increments are 8791293 (60 Hz) and 8864320 (50 Hz).
- R3: line_num counts up by one on each line_tick and holds otherwise. On the line_tick of line LINES-1 it returns to 0, where LINES is 263 for 60 Hz and 313 for 50 Hz by default.
- R4: vblank_start pulses on the line_tick that moves line_num onto the blanking line (240 for 60 Hz, 256 for 50 Hz, by default). status bit 0 is set from the next clock and cleared on frame wrap.
- R5: frame_irq pulses on the line_tick at which line_num wraps, and frame_count increments by one at that edge.
- R6: audio_tick pulses on every AUD_LINES-th line_tick (32 by default), counting continuously across frame boundaries from reset.
- R7: std_sel (0 = 60 Hz, 1 = 50 Hz) is sampled only at frame wrap. A change to it affects the line count, the blanking line and the line increment starting with the first line of the next frame, and has no effect before that.
- R8: status bit 31 equals frame_count bit 0 while interlace_en is high, and is 0 otherwise. Status bits 30 to 1 are always 0.
- R9: vblank_start, frame_irq and audio_tick are single-clock pulses that occur only together with line_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_sel | input | 1 | Standard request: 0 = 60 Hz, 1 = 50 Hz |
| interlace_en | input | 1 | Enables the field bit in status |
| line_tick | output | 1 | Last clock of the current line |
| vblank_start | output | 1 | Pulse at entry to the blanking line |
| frame_irq | output | 1 | End-of-frame interrupt pulse |
| audio_tick | output | 1 | Periodic audio-update pulse |
| line_num | output | LW | Current line within the frame |
| frame_count | output | FW | Frames completed since reset |
| status | output | 32 | Bit 0 vertical blank, bit 31 field |

## Verification
The checker verifies the following on every cycle: every event pulse coincides with a line tick, the line number holds between ticks and returns to zero after a wrap, the frame count steps by one at a wrap, the blanking flag follows its set and clear events, and the field bit stays low without interlace. Several properties can only be shown by the bench's scenarios, because they depend on long-run arithmetic: the exact line-length pattern produced by the fractional carry, the audio period counted across frame boundaries, and the point at which a mid-frame change of standard takes hold.

// File: rtl/vid_seq.sv
module vid_seq #(
  parameter int INC60     = 8791293,
  parameter int INC50     = 8864320,
  parameter int LINES60   = 263,
  parameter int LINES50   = 313,
  parameter int VBL60     = 240,
  parameter int VBL50     = 256,
  parameter int AUD_LINES = 32,
  parameter int FRAC      = 12,
  parameter int CW        = 20,
  parameter int LW        = 9,
  parameter int FW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          std_sel,
  input  logic          interlace_en,
  output logic          line_tick,
  output logic          vblank_start,
  output logic          frame_irq,
  output logic          audio_tick,
  output logic [LW-1:0] line_num,
  output logic [FW-1:0] frame_count,
  output logic [31:0]   status
);
  localparam int SW = FRAC + CW;
  localparam int AW = $clog2(AUD_LINES + 1);
  localparam logic [SW-1:0] I60 = SW'(INC60);
  localparam logic [SW-1:0] I50 = SW'(INC50);
  localparam logic [LW-1:0] LAST60 = LW'(LINES60 - 1);
  localparam logic [LW-1:0] LAST50 = LW'(LINES50 - 1);
  localparam logic [LW-1:0] V60 = LW'(VBL60);
  localparam logic [LW-1:0] V50 = LW'(VBL50);
  localparam logic [AW-1:0] ALAST = AW'(AUD_LINES - 1);

  logic [CW-1:0]   cnt, len;
  logic [FRAC-1:0] frac;
  logic [AW-1:0]   aud;
  logic            std_q, vbl_q;

  wire  [LW-1:0] last_line = std_q ? LAST50 : LAST60;
  wire  [LW-1:0] vbl_line  = std_q ? V50 : V60;
  wire  [LW-1:0] line_inc  = line_num + LW'(1);
  wire           wrap      = line_tick && (line_num == last_line);
  wire           std_n     = wrap ? std_sel : std_q;
  wire  [SW-1:0] sum       = {{CW{1'b0}}, frac} + (std_n ? I50 : I60);

  assign line_tick    = (cnt == len - CW'(1));
  assign frame_irq    = wrap;
  assign vblank_start = line_tick && (line_inc == vbl_line);
  assign audio_tick   = line_tick && (aud == ALAST);
  assign status       = {interlace_en & frame_count[0], 30'b0, vbl_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      len         <= I60[SW-1:FRAC];
      frac        <= I60[FRAC-1:0];
      line_num    <= '0;
      frame_count <= '0;
      aud         <= '0;
      std_q       <= 1'b0;
      vbl_q       <= 1'b0;
    end else if (line_tick) begin
      cnt      <= '0;
      len      <= sum[SW-1:FRAC];
      frac     <= sum[FRAC-1:0];
      std_q    <= std_n;
      line_num <= wrap ? '0 : line_inc;
      aud      <= audio_tick ? '0 : aud + AW'(1);
      if (wrap) begin
        frame_count <= frame_count + FW'(1);
        vbl_q       <= 1'b0;
      end else if (vblank_start) begin
        vbl_q <= 1'b1;
      end
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/vid_seq_chk.sv
module vid_seq_chk #(
  parameter int LW = 9,
  parameter int FW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          interlace_en,
  input logic          line_tick,
  input logic          vblank_start,
  input logic          frame_irq,
  input logic          audio_tick,
  input logic [LW-1:0] line_num,
  input logic [FW-1:0] frame_count,
  input logic [31:0]   status
);
  assert_evt_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_irq || vblank_start || audio_tick) |-> line_tick);
  assert_line_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !line_tick |=> $stable(line_num));
  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> (line_num == '0));
  assert_frame_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> (frame_count == $past(frame_count) + FW'(1)));
  assert_frame_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_irq |=> $stable(frame_count));
  assert_vbl_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_start |=> status[0]);
  assert_vbl_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !status[0]);
  assert_field_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !interlace_en |-> !status[31]);
  assert_zero_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status[30:1] == '0);
endmodule

bind vid_seq vid_seq_chk #(.LW(LW), .FW(FW)) chk (
  .clk(clk), .rst_n(rst_n), .interlace_en(interlace_en), .line_tick(line_tick),
  .vblank_start(vblank_start), .frame_irq(frame_irq), .audio_tick(audio_tick),
  .line_num(line_num), .frame_count(frame_count), .status(status));

// File: tb/vid_seq_test.sv
module vid_seq_test;
  localparam int PERIOD = 10;
  localparam int I60 = 13312;   // 3.25 clocks per line
  localparam int I50 = 18432;   // 4.5 clocks per line
  localparam int L60 = 10, L50 = 12, V60 = 7, V50 = 9, AUD = 4;

  logic clk = 1'b0, rst_n = 1'b0, std_sel = 1'b0, interlace_en = 1'b0;
  logic line_tick, vblank_start, frame_irq, audio_tick;
  logic [8:0] line_num;
  logic [7:0] frame_count;
  logic [31:0] status;

  vid_seq #(.INC60(I60), .INC50(I50), .LINES60(L60), .LINES50(L50),
            .VBL60(V60), .VBL50(V50), .AUD_LINES(AUD)) uut (
    .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .interlace_en(interlace_en),
    .line_tick(line_tick), .vblank_start(vblank_start), .frame_irq(frame_irq),
    .audio_tick(audio_tick), .line_num(line_num), .frame_count(frame_count),
    .status(status));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit running = 0, done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      if (fails < 25) $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // arithmetic reference state
  int m_cnt, m_len, m_frac, m_line, m_aud, m_frame, m_std, m_vbl;
  int m_wraps60, m_wraps50;

  function automatic int inc_of(input int s); return s ? I50 : I60; endfunction
  function automatic int last_of(input int s); return s ? L50 - 1 : L60 - 1; endfunction
  function automatic int vbl_of(input int s); return s ? V50 : V60; endfunction

  always @(negedge clk) if (running) begin
    bit t, w, v, a;
    int s, nstd;
    t = (m_cnt == m_len - 1);
    w = t && (m_line == last_of(m_std));
    v = t && (m_line + 1 == vbl_of(m_std));
    a = t && (m_aud == AUD - 1);
    check(line_tick == t, "R2 line_tick", line_tick, t);
    check(line_num == m_line, "R3 line_num", line_num, m_line);
    check(vblank_start == v, "R4 vblank_start", vblank_start, v);
    check(status[0] == m_vbl, "R4 vblank flag", status[0], m_vbl);
    check(frame_irq == w, "R5 frame_irq", frame_irq, w);
    check(frame_count == m_frame[7:0], "R5 frame_count", frame_count, m_frame[7:0]);
    check(audio_tick == a, "R6 audio_tick", audio_tick, a);
    check(status[31] == (interlace_en & m_frame[0]), "R8 field bit", status[31], interlace_en & m_frame[0]);
    check(status[30:1] == 0, "R8 zero bits", status[30:1], 0);
    if (t) begin
      nstd = w ? int'(std_sel) : m_std;   // R7: standard changes only at wrap
      if (w) begin
        if (m_std) m_wraps50++; else m_wraps60++;
      end
      s = m_frac + inc_of(nstd);
      m_len = s >>> 12;
      m_frac = s & 4095;
      m_cnt = 0;
      m_line = w ? 0 : m_line + 1;
      if (w) m_vbl = 0; else if (v) m_vbl = 1;
      m_aud = a ? 0 : m_aud + 1;
      m_frame += w;
      m_std = nstd;
    end else m_cnt++;
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    m_cnt = 0; m_len = I60 >>> 12; m_frac = I60 & 4095; m_line = 0;
    m_aud = 0; m_frame = 0; m_std = 0; m_vbl = 0; m_wraps60 = 0; m_wraps50 = 0;
    #(PERIOD*3 + 2);
    // R1: reset state
    check(line_num == 0, "R1 line_num", line_num, 0);
    check(frame_count == 0, "R1 frame_count", frame_count, 0);
    check(status == 0, "R1 status", status, 0);
    check(line_tick == 0, "R1 line_tick", line_tick, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    running = 1;
    run(120);
    std_sel = 1'b1;          // R7: mid-frame request
    run(15);
    interlace_en = 1'b1;
    run(220);
    std_sel = 1'b0;
    run(40);
    interlace_en = 1'b0;
    run(40);
    interlace_en = 1'b1;
    run(160);
    running = 0;
    #2;
    check(m_wraps60 >= 3, "R7 frames at 60 Hz", m_wraps60, 3);
    check(m_wraps50 >= 3, "R7 frames at 50 Hz", m_wraps50, 3);
    check(frame_count == m_frame[7:0], "R5 final frame_count", frame_count, m_frame[7:0]);
    finish_up();
  end

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end
endmodule